// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This block watches the instruction-fetch, data load/store and port I/O traffic of a simple processor core and compares every access against four programmable breakpoint slots. Each slot holds an address, a two-bit access-type code and a two-bit length code, plus a local and a global enable. An enabled execute-type match is reported as a fault in the same cycle as the fetch, so the instruction has not yet run. An enabled data or port match is reported as a trap one cycle later, after the access has completed.

The block also keeps the trap flag and the resume flag. The trap flag gives single-step traps. The resume flag masks execute matches for one instruction. A general-detect bit protects the breakpoint registers themselves, and a task-switch pulse drops the local enables. Software reaches the slots and the control and status words through a small register port. That port is usable only at privilege level 0.

Top module: `hw_bkpt_unit`

## Requirements
- R1: After reset, the control word (index 4) and the status word (index 5) read as 0, and exec_fault, data_trap, step_trap, tf_q and rf_q are 0.
- R2: Slot i (0..3) counts as enabled when control bit i (local) or control bit 4+i (global) is 1. Only enabled slots raise exec_fault or data_trap.
- R3: A task_switch pulse clears control bits 3:0 at the next clock edge and leaves bits 7:4 unchanged.
- R4: Type code 00 (control bits 17+4i:16+4i) matches fetches only (acc_kind 00). exec_fault is raised combinationally in the same cycle as the matching fetch.
- R5: Type code 01 matches data writes only (acc_kind 01). data_trap is raised in the cycle after the matching access.
- R6: Type code 11 matches data reads (acc_kind 10) and data writes, and never matches a fetch.
- R7: Type code 10 matches port accesses (acc_kind 11) only while io_dbg_en is 1. While io_dbg_en is 0 it matches nothing.
- R8: Length code (control bits 19+4i:18+4i) 00, 01, 11 and 10 covers 1, 2, 4 and 8 bytes. The slot range starts at the stored address aligned down to that size. A slot matches when its range overlaps the access bytes (acc_size 00/01/10/11 = 1/2/4/8 bytes). An execute slot always covers only the single byte at its stored address.
- R9: Status bit i (3:0) sets whenever slot i matches, even while the slot is disabled. Status bits stay set until software writes the status word.
- R10: While rf_q is 1, execute-type matches are ignored: there is no exec_fault and no status bit. rf_q clears after the next instr_retire.
- R11: When tf_q is 1 and an instruction retires, step_trap is raised in the next cycle. In that same cycle status bit 14 sets and tf_q clears.
- R12: While control bit 8 is 1, any register access raises gd_fault in the same cycle and is refused (reg_ok 0). At the next edge, control bit 8 clears and status bit 13 sets.
- R13: A register access with reg_cpl other than 0 is refused: reg_ok is 0, reg_rdata is 0 and nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_idx | input | 3 | 0..3 slot address, 4 control, 5 status |
| reg_wdata | input | 32 | Write data |
| reg_cpl | input | 2 | Current privilege level of the access |
| reg_rdata | output | 32 | Read data (0 when refused) |
| reg_ok | output | 1 | Access accepted |
| gd_fault | output | 1 | General-detect fault |
| acc_valid | input | 1 | Observed access strobe |
| acc_kind | input | 2 | 00 fetch, 01 write, 10 read, 11 port I/O |
| acc_addr | input | ADDR_W | Access start address |
| acc_size | input | 2 | 00/01/10/11 = 1/2/4/8 bytes |
| io_dbg_en | input | 1 | Enables port-type breakpoints |
| exec_fault | output | 1 | Execute breakpoint fault, same cycle |
| data_trap | output | 1 | Data/port breakpoint trap, next cycle |
| task_switch | input | 1 | Task-switch pulse |
| flag_load | input | 1 | Loads tf_in/rf_in into the flags |
| tf_in | input | 1 | Trap flag load value |
| rf_in | input | 1 | Resume flag load value |
| instr_retire | input | 1 | Instruction retired pulse |
| tf_q | output | 1 | Current trap flag |
| rf_q | output | 1 | Current resume flag |
| step_trap | output | 1 | Single-step trap |

## Verification
exec_fault, gd_fault, reg_ok and reg_rdata are combinational. The bench samples them one time unit after it drives the inputs on a falling edge. data_trap and step_trap each pass through one register. The bench releases the stimulus at the following falling edge and samples them right after it. Status and control updates land at the rising edge after their cause, so the bench reads them back with a register read started on a later falling edge.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
    // Shared constants and encodings for the breakpoint unit.
    localparam int NSLOT     = 4;
    localparam int REG_W     = 32;
    localparam int GD_BIT    = 8;
    localparam int BD_BIT    = 13;
    localparam int BS_BIT    = 14;
    localparam int TYPE_LSB  = 16;
    localparam int SLOT_STEP = 4;
    localparam int IDX_CTRL  = 4;
    localparam int IDX_STAT  = 5;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_READ  = 2'b10,
        ACC_IO    = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        BT_EXEC = 2'b00,
        BT_WR   = 2'b01,
        BT_IO   = 2'b10,
        BT_RW   = 2'b11
    } brk_type_e;

    // Byte-count-minus-one for a slot length code.
    function automatic logic [3:0] slot_len_mask(input logic [1:0] code);
        case (code)
            2'b00:   slot_len_mask = 4'd0;
            2'b01:   slot_len_mask = 4'd1;
            2'b10:   slot_len_mask = 4'd7;
            default: slot_len_mask = 4'd3;
        endcase
    endfunction

    // Byte-count-minus-one for an access size code.
    function automatic logic [3:0] acc_len_mask(input logic [1:0] code);
        case (code)
            2'b00:   acc_len_mask = 4'd0;
            2'b01:   acc_len_mask = 4'd1;
            2'b10:   acc_len_mask = 4'd3;
            default: acc_len_mask = 4'd7;
        endcase
    endfunction
endpackage

// File: rtl/hbp_slot_cmp.sv
// Compares one observed access against one breakpoint slot.
// Assumes: address arithmetic does not wrap (one extra bit is carried).
// The hit is raw: enables are applied by the caller, the resume flag here.
module hbp_slot_cmp
    import hbp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] slot_addr,
    input  logic [1:0]        brk_type,
    input  logic [1:0]        brk_len,
    input  logic              acc_valid,
    input  logic [1:0]        acc_kind,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic              io_dbg_en,
    input  logic              rf,
    output logic              hit
);
    logic [3:0]      s_mask;
    logic [ADDR_W:0] s_lo, s_hi, a_lo, a_hi;
    logic            type_ok;

    // Decide whether the access kind is one this slot's type can catch.
    always_comb begin
        case (brk_type_e'(brk_type))
            BT_EXEC: type_ok = (acc_kind == ACC_FETCH) && !rf;
            BT_WR:   type_ok = (acc_kind == ACC_WRITE);
            BT_IO:   type_ok = (acc_kind == ACC_IO) && io_dbg_en;
            default: type_ok = (acc_kind == ACC_WRITE) || (acc_kind == ACC_READ);
        endcase
    end

    // Build both byte ranges and test for overlap.
    always_comb begin
        s_mask = (brk_type == BT_EXEC) ? 4'd0 : slot_len_mask(brk_len);
        s_lo   = {1'b0, slot_addr & ~ADDR_W'(s_mask)};
        s_hi   = s_lo + (ADDR_W+1)'(s_mask);
        a_lo   = {1'b0, acc_addr};
        a_hi   = a_lo + (ADDR_W+1)'(acc_len_mask(acc_size));
        hit    = acc_valid && type_ok && (a_lo <= s_hi) && (s_lo <= a_hi);
    end
endmodule

// File: rtl/hbp_step_ctl.sv
// Holds the trap and resume flags and produces the single-step trap.
// Assumes: instr_retire is a one-cycle pulse per retired instruction;
// a flag load takes priority over clearing in the same cycle.
module hbp_step_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_load,
    input  logic tf_in,
    input  logic rf_in,
    input  logic instr_retire,
    output logic tf_q,
    output logic rf_q,
    output logic step_now,
    output logic step_trap
);
    assign step_now = tf_q && instr_retire;

    // Update flags and register the single-step trap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tf_q      <= 1'b0;
            rf_q      <= 1'b0;
            step_trap <= 1'b0;
        end else begin
            step_trap <= step_now;
            if (flag_load) begin
                tf_q <= tf_in;
                rf_q <= rf_in;
            end else begin
                if (step_now)     tf_q <= 1'b0;
                if (instr_retire) rf_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/hw_bkpt_unit.sv
// Four-slot breakpoint match unit with its control/status registers.
// Assumes: the core stalls on exec_fault and gd_fault, and takes
// data_trap / step_trap as debug exceptions when they are raised.
module hw_bkpt_unit
    import hbp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [2:0]        reg_idx,
    input  logic [31:0]       reg_wdata,
    input  logic [1:0]        reg_cpl,
    output logic [31:0]       reg_rdata,
    output logic              reg_ok,
    output logic              gd_fault,
    input  logic              acc_valid,
    input  logic [1:0]        acc_kind,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic              io_dbg_en,
    output logic              exec_fault,
    output logic              data_trap,
    input  logic              task_switch,
    input  logic              flag_load,
    input  logic              tf_in,
    input  logic              rf_in,
    input  logic              instr_retire,
    output logic              tf_q,
    output logic              rf_q,
    output logic              step_trap
);
    logic [ADDR_W-1:0] slot_q [NSLOT];
    logic [REG_W-1:0]  ctrl_q, status_q, ctrl_d, status_d;
    logic [NSLOT-1:0]  raw_hit, en_hit;
    logic              step_now, wr_en;

    hbp_step_ctl u_step (
        .clk(clk), .rst_n(rst_n), .flag_load(flag_load), .tf_in(tf_in),
        .rf_in(rf_in), .instr_retire(instr_retire), .tf_q(tf_q),
        .rf_q(rf_q), .step_now(step_now), .step_trap(step_trap)
    );

    // One comparator per slot.
    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        hbp_slot_cmp #(.ADDR_W(ADDR_W)) u_cmp (
            .slot_addr(slot_q[i]),
            .brk_type (ctrl_q[TYPE_LSB + SLOT_STEP*i +: 2]),
            .brk_len  (ctrl_q[TYPE_LSB + SLOT_STEP*i + 2 +: 2]),
            .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_addr(acc_addr),
            .acc_size (acc_size), .io_dbg_en(io_dbg_en), .rf(rf_q),
            .hit      (raw_hit[i])
        );
        assign en_hit[i] = raw_hit[i] && (ctrl_q[i] || ctrl_q[NSLOT + i]);
    end

    // Register-port gating: general detect first, then privilege.
    always_comb begin
        gd_fault = reg_valid && ctrl_q[GD_BIT];
        reg_ok   = reg_valid && !ctrl_q[GD_BIT] && (reg_cpl == 2'd0);
        wr_en    = reg_ok && reg_write;
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (reg_ok) begin
            if (!reg_idx[2])               reg_rdata = REG_W'(slot_q[reg_idx[1:0]]);
            else if (reg_idx == IDX_CTRL)  reg_rdata = ctrl_q;
            else if (reg_idx == IDX_STAT)  reg_rdata = status_q;
        end
    end

    assign exec_fault = acc_valid && (acc_kind == ACC_FETCH) && (|en_hit);

    // Next control and status words from software and hardware events.
    always_comb begin
        ctrl_d   = ctrl_q;
        status_d = status_q;
        if (wr_en && reg_idx == IDX_CTRL) ctrl_d   = reg_wdata;
        if (wr_en && reg_idx == IDX_STAT) status_d = reg_wdata;
        if (gd_fault)    ctrl_d[GD_BIT] = 1'b0;
        if (task_switch) ctrl_d[NSLOT-1:0] = '0;
        status_d[NSLOT-1:0] = status_d[NSLOT-1:0] | raw_hit;
        if (gd_fault) status_d[BD_BIT] = 1'b1;
        if (step_now) status_d[BS_BIT] = 1'b1;
    end

    // State registers and the data trap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            status_q  <= '0;
            data_trap <= 1'b0;
            for (int i = 0; i < NSLOT; i++) slot_q[i] <= '0;
        end else begin
            ctrl_q    <= ctrl_d;
            status_q  <= status_d;
            data_trap <= acc_valid && (acc_kind != ACC_FETCH) && (|en_hit);
            if (wr_en && !reg_idx[2]) slot_q[reg_idx[1:0]] <= reg_wdata[ADDR_W-1:0];
        end
    end
endmodule

// File: rtl/hbp_chk.sv
// Property checker for hw_bkpt_unit, bound to every instance.
module hbp_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        task_switch,
    input logic        wr_ctrl,
    input logic [31:0] ctrl_q,
    input logic [31:0] status_q,
    input logic        data_trap,
    input logic        acc_valid,
    input logic [1:0]  acc_kind,
    input logic        exec_fault,
    input logic        rf_q,
    input logic        tf_q,
    input logic        step_trap,
    input logic        flag_load,
    input logic        instr_retire,
    input logic        gd_fault,
    input logic        reg_ok,
    input logic [1:0]  reg_cpl
);
    a_r3_local_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        task_switch |=> ctrl_q[3:0] == 4'd0);
    a_r3_global_kept: assert property (@(posedge clk) disable iff (!rst_n)
        task_switch && !wr_ctrl |=> ctrl_q[7:4] == $past(ctrl_q[7:4]));
    a_r4_fault_on_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        exec_fault |-> acc_valid && acc_kind == 2'b00);
    a_r5_trap_follows_data: assert property (@(posedge clk) disable iff (!rst_n)
        data_trap |-> $past(acc_valid && acc_kind != 2'b00));
    a_r10_resume_masks: assert property (@(posedge clk) disable iff (!rst_n)
        exec_fault |-> !rf_q);
    a_r11_step_cause: assert property (@(posedge clk) disable iff (!rst_n)
        step_trap |-> $past(tf_q && instr_retire));
    a_r11_step_clears_tf: assert property (@(posedge clk) disable iff (!rst_n)
        step_trap && !$past(flag_load) |-> !tf_q && status_q[14]);
    a_r12_gd_effect: assert property (@(posedge clk) disable iff (!rst_n)
        gd_fault |=> !ctrl_q[8] && status_q[13]);
    a_r13_priv_gate: assert property (@(posedge clk) disable iff (!rst_n)
        reg_ok |-> reg_cpl == 2'd0);
endmodule

bind hw_bkpt_unit hbp_chk u_hbp_chk (
    .clk(clk), .rst_n(rst_n), .task_switch(task_switch),
    .wr_ctrl(wr_en && reg_idx == 3'd4), .ctrl_q(ctrl_q), .status_q(status_q),
    .data_trap(data_trap), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .exec_fault(exec_fault), .rf_q(rf_q), .tf_q(tf_q), .step_trap(step_trap),
    .flag_load(flag_load), .instr_retire(instr_retire), .gd_fault(gd_fault),
    .reg_ok(reg_ok), .reg_cpl(reg_cpl)
);

// File: tb/hw_bkpt_unit_tb_top.sv
module hw_bkpt_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 0, reg_write = 0;
    logic [2:0]  reg_idx = 0;
    logic [31:0] reg_wdata = 0;
    logic [1:0]  reg_cpl = 0;
    logic [31:0] reg_rdata;
    logic        reg_ok, gd_fault;
    logic        acc_valid = 0;
    logic [1:0]  acc_kind = 0;
    logic [31:0] acc_addr = 0;
    logic [1:0]  acc_size = 0;
    logic        io_dbg_en = 0;
    logic        exec_fault, data_trap;
    logic        task_switch = 0, flag_load = 0, tf_in = 0, rf_in = 0, instr_retire = 0;
    logic        tf_q, rf_q, step_trap;
    int          total = 0, bad = 0;
    bit          done = 0;

    always #4 clk = ~clk;  // 125 MHz

    hw_bkpt_unit #(.ADDR_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_cpl(reg_cpl),
        .reg_rdata(reg_rdata), .reg_ok(reg_ok), .gd_fault(gd_fault),
        .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_addr(acc_addr),
        .acc_size(acc_size), .io_dbg_en(io_dbg_en), .exec_fault(exec_fault),
        .data_trap(data_trap), .task_switch(task_switch), .flag_load(flag_load),
        .tf_in(tf_in), .rf_in(rf_in), .instr_retire(instr_retire),
        .tf_q(tf_q), .rf_q(rf_q), .step_trap(step_trap)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] slot_cfg(input int s, input logic [1:0] t, input logic [1:0] l);
        return (32'(t) << (16 + 4*s)) | (32'(l) << (18 + 4*s));
    endfunction

    task automatic reg_wr(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1; reg_write = 1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_valid = 0; reg_write = 0;
    endtask

    task automatic reg_rd(input logic [2:0] idx, output logic [31:0] d, output logic ok);
        @(negedge clk);
        reg_valid = 1; reg_write = 0; reg_idx = idx;
        #1 d = reg_rdata; ok = reg_ok;
        @(negedge clk);
        reg_valid = 0;
    endtask

    task automatic access(input logic [1:0] k, input logic [31:0] a, input logic [1:0] sz,
                          output logic f, output logic t);
        @(negedge clk);
        acc_valid = 1; acc_kind = k; acc_addr = a; acc_size = sz;
        #1 f = exec_fault;
        @(negedge clk);
        acc_valid = 0;
        #1 t = data_trap;
    endtask

    task automatic t_reset();
        logic [31:0] d; logic ok;
        reg_rd(3'd4, d, ok); chk("R1 ctrl", d, 0);
        reg_rd(3'd5, d, ok); chk("R1 status", d, 0);
        chk("R1 outputs", {exec_fault, data_trap, step_trap, tf_q, rf_q}, 0);
    endtask

    task automatic t_exec();
        logic f, t; logic [31:0] d; logic ok;
        reg_wr(3'd0, 32'h1000);
        reg_wr(3'd4, 32'h10 | slot_cfg(0, 2'b00, 2'b11));  // G0, exec, len ignored
        reg_wr(3'd5, 0);
        access(2'b00, 32'h1000, 2'b00, f, t); chk("R4 fetch hit fault", f, 1); chk("R4 no trap", t, 0);
        access(2'b00, 32'h1001, 2'b00, f, t); chk("R8 exec slot one byte", f, 0);
        access(2'b10, 32'h1000, 2'b00, f, t); chk("R4 read no trap", t, 0);
        reg_rd(3'd5, d, ok); chk("R9 status B0", d, 1);
    endtask

    task automatic t_write();
        logic f, t;
        reg_wr(3'd1, 32'h2002);
        reg_wr(3'd4, 32'h02 | slot_cfg(1, 2'b01, 2'b11));  // L1, write, 4 bytes
        access(2'b01, 32'h2003, 2'b00, f, t); chk("R5 write hit trap", t, 1); chk("R5 no fault", f, 0);
        access(2'b10, 32'h2000, 2'b00, f, t); chk("R5 read ignored", t, 0);
        access(2'b01, 32'h1FFE, 2'b10, f, t); chk("R8 overlap from below", t, 1);
        access(2'b01, 32'h2004, 2'b00, f, t); chk("R8 past range", t, 0);
    endtask

    task automatic t_rw_len();
        logic f, t;
        reg_wr(3'd2, 32'h3000);
        reg_wr(3'd4, 32'h40 | slot_cfg(2, 2'b11, 2'b01));  // G2, rw, 2 bytes
        access(2'b10, 32'h3001, 2'b00, f, t); chk("R6 read hit", t, 1);
        access(2'b00, 32'h3000, 2'b00, f, t); chk("R6 fetch ignored", f, 0); chk("R6 fetch no trap", t, 0);
        reg_wr(3'd2, 32'h4005);
        reg_wr(3'd4, 32'h40 | slot_cfg(2, 2'b11, 2'b10));  // 8 bytes
        access(2'b01, 32'h4007, 2'b00, f, t); chk("R8 eight-byte hit", t, 1);
        access(2'b01, 32'h4008, 2'b00, f, t); chk("R8 eight-byte end", t, 0);
    endtask

    task automatic t_io();
        logic f, t;
        reg_wr(3'd3, 32'h60);
        reg_wr(3'd4, 32'h80 | slot_cfg(3, 2'b10, 2'b00));  // G3, io
        io_dbg_en = 0;
        access(2'b11, 32'h60, 2'b00, f, t); chk("R7 io disabled", t, 0);
        io_dbg_en = 1;
        access(2'b11, 32'h60, 2'b00, f, t); chk("R7 io enabled", t, 1);
        access(2'b01, 32'h60, 2'b00, f, t); chk("R7 memory write ignored", t, 0);
        io_dbg_en = 0;
    endtask

    task automatic t_disabled();
        logic f, t; logic [31:0] d; logic ok;
        reg_wr(3'd0, 32'h1000);
        reg_wr(3'd4, slot_cfg(0, 2'b00, 2'b00));  // no enables
        reg_wr(3'd5, 0);
        access(2'b00, 32'h1000, 2'b00, f, t); chk("R2 disabled no fault", f, 0);
        reg_rd(3'd5, d, ok); chk("R9 status set while disabled", d, 1);
    endtask

    task automatic t_task_switch();
        logic [31:0] d; logic ok;
        reg_wr(3'd4, 32'h5F);
        @(negedge clk); task_switch = 1;
        @(negedge clk); task_switch = 0;
        reg_rd(3'd4, d, ok); chk("R3 locals cleared globals kept", d, 32'h50);
    endtask

    task automatic t_resume();
        logic f, t; logic [31:0] d; logic ok;
        reg_wr(3'd0, 32'h1000);
        reg_wr(3'd4, 32'h10);
        reg_wr(3'd5, 0);
        @(negedge clk); flag_load = 1; rf_in = 1; tf_in = 0;
        @(negedge clk); flag_load = 0; rf_in = 0;
        access(2'b00, 32'h1000, 2'b00, f, t); chk("R10 fault suppressed", f, 0);
        reg_rd(3'd5, d, ok); chk("R10 no status", d, 0);
        @(negedge clk); instr_retire = 1;
        @(negedge clk); instr_retire = 0;
        #1 chk("R10 rf cleared", rf_q, 0);
        access(2'b00, 32'h1000, 2'b00, f, t); chk("R10 fault returns", f, 1);
    endtask

    task automatic t_step();
        logic [31:0] d; logic ok;
        reg_wr(3'd4, 0);
        reg_wr(3'd5, 0);
        @(negedge clk); flag_load = 1; tf_in = 1;
        @(negedge clk); flag_load = 0; tf_in = 0;
        #1 chk("R11 no trap before retire", step_trap, 0);
        @(negedge clk); instr_retire = 1;
        @(negedge clk); instr_retire = 0;
        #1 chk("R11 step trap", step_trap, 1); chk("R11 tf cleared", tf_q, 0);
        reg_rd(3'd5, d, ok); chk("R11 BS set", d, 32'h4000);
    endtask

    task automatic t_gd();
        logic [31:0] d; logic ok;
        reg_wr(3'd5, 0);
        reg_wr(3'd4, 32'h100);
        @(negedge clk); reg_valid = 1; reg_write = 1; reg_idx = 3'd4; reg_wdata = 32'h33;
        #1 chk("R12 gd fault", gd_fault, 1); chk("R12 refused", reg_ok, 0);
        @(negedge clk); reg_valid = 0; reg_write = 0;
        reg_rd(3'd4, d, ok); chk("R12 gd cleared, write dropped", d, 0); chk("R12 ok after", ok, 1);
        reg_rd(3'd5, d, ok); chk("R12 BD set", d, 32'h2000);
    endtask

    task automatic t_priv();
        logic [31:0] d; logic ok;
        reg_wr(3'd4, 32'h10);
        reg_cpl = 2'd3;
        reg_wr(3'd4, 32'hFF);
        reg_rd(3'd4, d, ok); chk("R13 refused", ok, 0); chk("R13 rdata zero", d, 0);
        reg_cpl = 2'd0;
        reg_rd(3'd4, d, ok); chk("R13 no write", d, 32'h10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_exec();
        t_write();
        t_rw_len();
        t_io();
        t_disabled();
        t_task_switch();
        t_resume();
        t_step();
        t_gd();
        t_priv();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule